// File: doc/BRIEF.md
# Write-Only Serial Host Byte Receiver

This block receives bytes from a host over a two-wire synchronous serial link when the host-interface strap selects serial operation. Two lanes of the shared data-pin bus are reused: one carries the serial data bit and the other carries the serial clock. A separate address-type input marks each byte as either a command or a display-data byte. The receiver samples every pin with the system clock through a synchronizer and finds serial clock rising edges there. When eight bits have arrived under an active chip select, it presents the byte, its tag and a one-cycle strobe to the command decoder.

The serial link only carries writes. No read-back path exists, so the block never drives the data pins in serial mode. In parallel mode, a neighbouring parallel-bus block supplies the pad output enables, and this block only passes them through while the chip is selected.

Top module: `ser_host_rx`

## Requirements
- R1: Serial reception is active only when `bus_par_sel` is 0. With `bus_par_sel` at 1, no byte strobe is ever produced, whatever happens on the pins.
- R2: The serial data bit is `bus_pins[7]` and the serial clock is `bus_pins[6]`. Bits are taken on each rising serial clock edge, most significant bit first, so the first bit received lands in `rx_byte[7]`.
- R3: After the eighth bit of a byte, `rx_valid` is high for exactly one system clock cycle, and `rx_byte` holds the received byte.
- R4: `rx_is_data` is 1 when the address-type input `bus_a0` was 1 at the eighth bit (display data), and 0 when it was 0 (command).
- R5: Serial clock edges count only while `bus_cs1_n` is 0 and `bus_cs2` is 1. Edges seen with either select inactive produce no byte.
- R6: When the chip select goes inactive, the bit count returns to zero, so a partial byte is discarded. The next byte starts afresh.
- R7: In serial mode, `pin_oe` is all zero, which leaves every data pin high impedance. In parallel mode with the chip selected, `pin_oe` equals `par_rd_oe`; otherwise it is zero.
- R8: During and after reset, `rx_valid` is 0, `rx_byte` is 0 and `rx_is_data` is 0.
- R9: Consecutive bytes under one continuous chip select are each framed and strobed separately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_par_sel | input | 1 | Host interface strap: 1 parallel, 0 serial |
| bus_cs1_n | input | 1 | Chip select, active low |
| bus_cs2 | input | 1 | Chip select, active high |
| bus_a0 | input | 1 | Byte type: 1 display data, 0 command |
| bus_pins | input | 8 | Shared data pins (bit 7 serial data, bit 6 serial clock) |
| par_rd_oe | input | 8 | Pad output enables requested by the parallel path |
| pin_oe | output | 8 | Pad output enables for the data pins |
| rx_byte | output | 8 | Last received byte |
| rx_is_data | output | 1 | Tag of the last byte: 1 data, 0 command |
| rx_valid | output | 1 | One-cycle strobe for a completed byte |

## Verification
On every cycle, the assertions check that the strobe lasts one cycle, that a strobe needs a selected serial interface on the cycle before, that the bit counter advances by one per qualified edge, that it is zero after a deselect, and that the pads are undriven in serial mode. Only the bench scenarios can show the bit order, the value and tag of each byte, that a partial byte is discarded when the select is dropped, and that traffic is ignored in parallel mode or with either select inactive.

// File: rtl/ser_host_rx_pkg.sv
package ser_host_rx_pkg;
   // Bundle of raw host-side inputs passed through one synchronizer.
   typedef struct packed {
      logic a0;
      logic cs1_n;
      logic cs2;
      logic par_sel;
      logic sdata;
      logic sclk;
   } host_in_t;

   localparam int HOST_IN_W = $bits(host_in_t);
endpackage

// File: rtl/ser_host_rx_sync.sv
module ser_host_rx_sync #(
   parameter int W      = 6,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[0] <= '0;
               else        stg[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[i] <= '0;
               else        stg[i] <= stg[i-1];
            end
         end
      end
   endgenerate

   assign q = stg[STAGES-1];
endmodule

// File: rtl/ser_host_rx_framer.sv
module ser_host_rx_framer #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              sclk,
   input  logic              sdata,
   input  logic              a0,
   output logic [BYTE_W-1:0] rx_byte,
   output logic              rx_is_data,
   output logic              rx_valid
);
   localparam int CW = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
   localparam logic [CW-1:0] LAST = CW'(BYTE_W - 1);

   logic              sclk_d;
   logic              rise;
   logic [CW-1:0]     cnt;
   logic [BYTE_W-1:0] shreg;
   logic [BYTE_W-1:0] next_sh;

   assign rise    = sclk & ~sclk_d;
   assign next_sh = {shreg[BYTE_W-2:0], sdata};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d     <= 1'b0;
         cnt        <= '0;
         shreg      <= '0;
         rx_byte    <= '0;
         rx_is_data <= 1'b0;
         rx_valid   <= 1'b0;
      end else begin
         sclk_d   <= sclk;
         rx_valid <= 1'b0;
         if (!sel) begin
            cnt <= '0;
         end else if (rise) begin
            shreg <= next_sh;
            if (cnt == LAST) begin
               cnt        <= '0;
               rx_byte    <= next_sh;
               rx_is_data <= a0;
               rx_valid   <= 1'b1;
            end else begin
               cnt <= cnt + CW'(1);
            end
         end
      end
   end

   // R3: the strobe never lasts two cycles
   a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);
   // R5: a strobe requires a selected serial interface one cycle earlier
   a_r5_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> $past(sel));
   // R6: deselect leaves the bit count at zero
   a_r6_clear_on_deselect: assert property (@(posedge clk) disable iff (!rst_n)
      !sel |=> cnt == '0);
   // R2: each qualified edge before the last bit advances the count by one
   a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && rise && cnt != LAST) |=> cnt == $past(cnt) + CW'(1));
endmodule

// File: rtl/ser_host_rx_padctl.sv
module ser_host_rx_padctl #(
   parameter int BUS_W = 8
) (
   input  logic             par_sel,
   input  logic             cs1_n,
   input  logic             cs2,
   input  logic [BUS_W-1:0] par_rd_oe,
   output logic [BUS_W-1:0] pin_oe
);
   logic chip_on;
   assign chip_on = ~cs1_n & cs2;

   always_comb begin
      pin_oe = '0;
      if (par_sel && chip_on) pin_oe = par_rd_oe;
   end

   // R7: serial mode never drives a pad
   always_comb begin
      if (!par_sel) a_r7_pads_float: assert (pin_oe == '0);
   end
endmodule

// File: rtl/ser_host_rx.sv
module ser_host_rx
   import ser_host_rx_pkg::*;
#(
   parameter int BUS_W       = 8,
   parameter int BYTE_W      = 8,
   parameter int SDATA_LANE  = 7,
   parameter int SCLK_LANE   = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_par_sel,
   input  logic              bus_cs1_n,
   input  logic              bus_cs2,
   input  logic              bus_a0,
   input  logic [BUS_W-1:0]  bus_pins,
   input  logic [BUS_W-1:0]  par_rd_oe,
   output logic [BUS_W-1:0]  pin_oe,
   output logic [BYTE_W-1:0] rx_byte,
   output logic              rx_is_data,
   output logic              rx_valid
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (SDATA_LANE == SCLK_LANE) begin : g_bad_lane
         $error("data and clock lanes must differ");
      end
      if (SDATA_LANE >= BUS_W || SCLK_LANE >= BUS_W) begin : g_bad_range
         $error("serial lanes must lie inside the pin bus");
      end
      if (BYTE_W < 2) begin : g_bad_byte
         $error("BYTE_W must be at least 2");
      end
   endgenerate

   host_in_t raw_in, syn_in;
   logic     sel;
   logic     pins_unused;

   assign pins_unused = ^bus_pins;

   assign raw_in = '{a0:      bus_a0,
                     cs1_n:   bus_cs1_n,
                     cs2:     bus_cs2,
                     par_sel: bus_par_sel,
                     sdata:   bus_pins[SDATA_LANE],
                     sclk:    bus_pins[SCLK_LANE]};

   ser_host_rx_sync #(.W(HOST_IN_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_in),
      .q     (syn_in)
   );

   assign sel = ~syn_in.par_sel & ~syn_in.cs1_n & syn_in.cs2;

   ser_host_rx_framer #(.BYTE_W(BYTE_W)) u_framer (
      .clk        (clk),
      .rst_n      (rst_n),
      .sel        (sel),
      .sclk       (syn_in.sclk),
      .sdata      (syn_in.sdata),
      .a0         (syn_in.a0),
      .rx_byte    (rx_byte),
      .rx_is_data (rx_is_data),
      .rx_valid   (rx_valid)
   );

   ser_host_rx_padctl #(.BUS_W(BUS_W)) u_pad (
      .par_sel   (bus_par_sel),
      .cs1_n     (bus_cs1_n),
      .cs2       (bus_cs2),
      .par_rd_oe (par_rd_oe),
      .pin_oe    (pin_oe)
   );

   // R1: no strobe unless the synchronized strap chose serial mode
   a_r1_serial_only: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> !$past(syn_in.par_sel));
endmodule

// File: tb/tb_ser_host_rx.sv
module tb_ser_host_rx;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       par_sel, cs1_n, cs2, a0;
   logic [7:0] pins, rd_oe, oe, rbyte;
   logic       is_data, valid;

   int errors = 0;
   int checks = 0;
   int vhigh  = 0;
   logic [7:0] last_byte = 8'h00;
   logic       last_tag  = 1'b0;
   bit         done = 0;

   always #4 clk = ~clk;

   ser_host_rx dut (
      .clk(clk), .rst_n(rst_n), .bus_par_sel(par_sel), .bus_cs1_n(cs1_n),
      .bus_cs2(cs2), .bus_a0(a0), .bus_pins(pins), .par_rd_oe(rd_oe),
      .pin_oe(oe), .rx_byte(rbyte), .rx_is_data(is_data), .rx_valid(valid)
   );

   // Monitor samples away from the active edge; each high sample is one cycle.
   always @(negedge clk) begin
      if (rst_n && valid) begin
         vhigh++;
         last_byte = rbyte;
         last_tag  = is_data;
      end
   end

   // {a0, byte}
   localparam logic [8:0] VEC [6] = '{9'h1A5, 9'h05A, 9'h100, 9'h0FF, 9'h181, 9'h03C};

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_bits(input logic [7:0] b, input int n);
      for (int i = 7; i > 7 - n; i--) begin
         pins[7] = b[i];
         idle(16);
         pins[6] = 1'b1;
         idle(16);
         pins[6] = 1'b0;
      end
      idle(8);
   endtask

   task automatic select(input logic on);
      cs1_n = ~on;
      cs2   = on;
      idle(6);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int base;
      rst_n = 1'b0; par_sel = 1'b0; cs1_n = 1'b1; cs2 = 1'b0; a0 = 1'b0;
      pins = 8'h00; rd_oe = 8'hFF;
      idle(5);
      // R8: reset state
      chk("R8 valid", valid, 0);
      chk("R8 byte", rbyte, 0);
      chk("R8 tag", is_data, 0);
      rst_n = 1'b1;
      idle(5);
      chk("R8 after reset", {valid, rbyte, is_data}, 0);

      // R2 R3 R4 table of bytes, one per select window
      for (int k = 0; k < 6; k++) begin
         a0 = VEC[k][8];
         select(1'b1);
         base = vhigh;
         send_bits(VEC[k][7:0], 8);
         chk("R3 one-cycle strobe", vhigh - base, 1);
         chk("R2 byte value", last_byte, VEC[k][7:0]);
         chk("R4 tag", last_tag, VEC[k][8]);
         select(1'b0);
      end

      // R7: pads float in serial mode even while selected
      select(1'b1);
      chk("R7 serial oe", oe, 0);
      select(1'b0);

      // R9: back-to-back bytes under one select
      select(1'b1);
      base = vhigh;
      a0 = 1'b0; send_bits(8'hC3, 8);
      chk("R9 first byte", last_byte, 8'hC3);
      chk("R9 first tag", last_tag, 0);
      a0 = 1'b1; send_bits(8'h3E, 8);
      chk("R9 second byte", last_byte, 8'h3E);
      chk("R9 second tag", last_tag, 1);
      chk("R9 strobe count", vhigh - base, 2);

      // R6: partial byte discarded by deselect
      a0 = 1'b0;
      send_bits(8'hE0, 3);
      select(1'b0);
      select(1'b1);
      base = vhigh;
      send_bits(8'h69, 8);
      chk("R6 strobe count", vhigh - base, 1);
      chk("R6 fresh byte", last_byte, 8'h69);
      select(1'b0);

      // R5: cs1_n high ignored, then cs2 low ignored
      base = vhigh;
      cs1_n = 1'b1; cs2 = 1'b1; idle(6);
      send_bits(8'h11, 8);
      cs1_n = 1'b0; cs2 = 1'b0; idle(6);
      send_bits(8'h22, 8);
      chk("R5 no strobe", vhigh - base, 0);
      chk("R5 byte held", rbyte, 8'h69);
      select(1'b0);

      // R1: parallel mode ignores serial traffic; R7 oe pass-through
      par_sel = 1'b1;
      select(1'b1);
      base = vhigh;
      send_bits(8'h77, 8);
      chk("R1 no strobe", vhigh - base, 0);
      chk("R1 byte held", rbyte, 8'h69);
      rd_oe = 8'h5A; idle(1);
      chk("R7 parallel oe", oe, 8'h5A);
      select(1'b0);
      chk("R7 deselected oe", oe, 0);
      par_sel = 1'b0;
      idle(6);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule